// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-visible control and status bank of a 64-channel DMA controller. It holds five per-channel flags for each channel: request enable, error-interrupt enable, interrupt pending, error pending and done. Each flag vector is split into a low word for channels 0..31 and a high word for channels 32..63. Software reaches the bank over a simple 32-bit register bus. Whole-word registers give bulk access. Byte-wide command lanes act on a single channel: software writes the channel number into the lane, and the block sets or clears that one channel's bit. This avoids a read-modify-write sequence.

The channel engines report completions on a per-channel event vector. They report failures as one error event that carries a channel number and a cause vector. The first failure is captured in an error status word, which holds its channel and causes until software has cleared every error flag. A single interrupt line combines pending completions with those errors whose interrupt is enabled. The block also drives the per-channel request enables, a one-cycle start pulse per channel, and three controller mode bits to the engines and the arbiter.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `chanReqEn`, `chanStart` and the mode outputs are 0.
- R2: A write to word 0x08 acts on request enables. Its byte lane 0 sets the request enable of the channel whose number it carries, and lane 1 clears it. Channels 0..31 read at bit `ch` of word 0x10 and channels 32..63 at bit `ch-32` of word 0x14. `chanReqEn` follows these bits. If one write sets and clears the same channel, the clear wins.
- R3: Lanes 2 and 3 of word 0x08 set and clear the error-interrupt enable of one channel. These enables read back in words 0x18 (low) and 0x1C (high).
- R4: A command lane carrying a value of 64 or more changes no state and produces no start pulse.
- R5: A full-word write to an enable word (0x10, 0x14, 0x18, 0x1C) replaces that half of the enable vector with the written data.
- R6: A completion event on `evDone[ch]` sets the channel's interrupt-pending bit (words 0x20/0x24) and its done bit (words 0x30/0x34). Lane 0 of word 0x0C clears one pending bit, and lane 3 of word 0x0C clears one done bit.
- R7: A write to an interrupt-pending word or an error word clears each flag whose data bit is 1. Writing all-ones therefore empties that half.
- R8: An error event sets the channel's error flag (words 0x28/0x2C). If the valid bit of the status word at 0x04 is clear, the event is also latched there. The latched word has bit 31 = valid, bits 15:14 = `errEvCause[9:8]` (group priority, channel priority), bits 13:8 = channel number, and bits 7:0 = `errEvCause[7:0]`.
- R9: While the valid bit is set, later errors leave the status word unchanged. Once the error flags are all zero (after lane 1 of word 0x0C or a word clear), the status word reads zero from the next cycle.
- R10: `irq` is 1 exactly when any interrupt-pending bit is set, or when any error flag is set together with its error-interrupt enable.
- R11: Lane 2 of word 0x0C raises `chanStart[ch]` for exactly the one cycle after the write.
- R12: If a completion or error event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R13: Word 0x00 keeps bits 31, 3 and 2, which drive `clkGateEn`, `rrGroup` and `rrChan`. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 8 | Byte address of the word register |
| busBe | input | 4 | Byte-lane enables, used by command words |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| evDone | input | 64 | Per-channel completion events |
| errEvValid | input | 1 | Error event strobe |
| errEvChan | input | 6 | Channel that failed |
| errEvCause | input | 10 | Error cause vector |
| irq | output | 1 | Combined interrupt |
| chanReqEn | output | 64 | Request enable per channel |
| chanStart | output | 64 | One-cycle start pulse per channel |
| clkGateEn | output | 1 | Dynamic clock gating mode |
| rrGroup | output | 1 | Round-robin group arbitration mode |
| rrChan | output | 1 | Round-robin channel arbitration mode |

## Verification
A wrong per-channel decode sets or clears a neighbour's bit. This shows up in the readback of both words on the next cycle, so the bench sweeps every channel through every command lane. A stuck or early-clearing valid bit shows up at the status word and at `irq` one cycle after the event or clear that should have changed it. The ordering of first and later errors and of partial and full clears is therefore driven step by step. Set-versus-clear collisions are forced in one cycle, because a wrong priority loses a completion silently and leaves only a missing bit.

// File: rtl/dmaregs_pkg.sv
package dmaregs_pkg;
  localparam int WORD_SEL_W = 16;
  localparam int CMD_N      = 8;
  localparam int ES_CHAN_W  = 6;
  localparam int ES_CAUSE_W = 10;

  // word register map (word index = byte address / 4)
  localparam int W_CTRL     = 0;
  localparam int W_ERRSTAT  = 1;
  localparam int W_CMDA     = 2;
  localparam int W_CMDB     = 3;
  localparam int W_REQEN_LO = 4;
  localparam int W_EIE_LO   = 6;
  localparam int W_INT_LO   = 8;
  localparam int W_ERR_LO   = 10;
  localparam int W_DONE_LO  = 12;

  // command lanes: 0..3 live in W_CMDA, 4..7 in W_CMDB
  localparam int C_SET_REQ   = 0;
  localparam int C_CLR_REQ   = 1;
  localparam int C_SET_EIE   = 2;
  localparam int C_CLR_EIE   = 3;
  localparam int C_CLR_INT   = 4;
  localparam int C_CLR_ERR   = 5;
  localparam int C_SET_START = 6;
  localparam int C_CLR_DONE  = 7;

  localparam logic [31:0] CTRL_MASK = 32'h8000_000C;
  localparam int ES_VALID = 31;

  typedef struct packed {
    logic [WORD_SEL_W-1:0]   wordSel;
    logic [31:0]             wrData;
    logic [CMD_N-1:0]        cmdHit;
    logic [CMD_N-1:0][7:0]   cmdIdx;
  } strobes_t;
endpackage

// File: rtl/dmaregs_decode.sv
module dmaregs_decode
  import dmaregs_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  output strobes_t          strb
);
  localparam int WI_W = ADDR_W - 2;

  logic [WI_W-1:0] wordIdx;
  logic [1:0]      unusedLow;

  assign wordIdx   = busAddr[ADDR_W-1:2];
  assign unusedLow = busAddr[1:0];

  always_comb begin
    strb        = '0;
    strb.wrData = busWdata;
    for (int w = 0; w < WORD_SEL_W; w++)
      strb.wordSel[w] = busWe && (wordIdx == WI_W'(w));
    for (int c = 0; c < CMD_N; c++) begin
      strb.cmdIdx[c] = busWdata[8*(c%4) +: 8];
      strb.cmdHit[c] = busWe && busBe[c%4]
                       && (wordIdx == WI_W'((c < 4) ? W_CMDA : W_CMDB))
                       && (int'(strb.cmdIdx[c]) < NUM_CH);
    end
  end

  // R4
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |-> (strb.cmdHit == '0 && strb.wordSel == '0));
endmodule

// File: rtl/dmaregs_bank.sv
module dmaregs_bank
  import dmaregs_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              strb,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [NUM_CH-1:0]     evDone,
  input  logic                  errEvValid,
  input  logic [ES_CHAN_W-1:0]  errEvChan,
  input  logic [ES_CAUSE_W-1:0] errEvCause,
  output logic [31:0]           rdData,
  output logic                  irq,
  output logic [NUM_CH-1:0]     reqEnOut,
  output logic [NUM_CH-1:0]     startOut,
  output logic [2:0]            ctrlOut
);
  localparam int VIEW_W = 64;
  localparam int WI_W   = ADDR_W - 2;

  logic [NUM_CH-1:0] reqEn, eie, intReq, errFlag, doneFlag, startQ;
  logic [NUM_CH-1:0] reqEnN, eieN, intReqN, errFlagN, doneN, startN;
  logic [31:0]       ctrlReg, errStat, errStatNew;
  logic              errLatch;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int HALF = i / 32;
    localparam int BIT  = i % 32;
    localparam logic [7:0] IDX = 8'(i);
    logic [CMD_N-1:0] hit;
    logic             errEv, wBit;
    for (genvar c = 0; c < CMD_N; c++) begin : g_cmd
      assign hit[c] = strb.cmdHit[c] && (strb.cmdIdx[c] == IDX);
    end
    assign wBit  = strb.wrData[BIT];
    assign errEv = errEvValid && (errEvChan == ES_CHAN_W'(i));
    assign reqEnN[i] = ~hit[C_CLR_REQ] & (hit[C_SET_REQ] |
                       (strb.wordSel[W_REQEN_LO+HALF] ? wBit : reqEn[i]));
    assign eieN[i]   = ~hit[C_CLR_EIE] & (hit[C_SET_EIE] |
                       (strb.wordSel[W_EIE_LO+HALF] ? wBit : eie[i]));
    assign intReqN[i]  = evDone[i] | (intReq[i] & ~hit[C_CLR_INT]
                         & ~(strb.wordSel[W_INT_LO+HALF] & wBit));
    assign errFlagN[i] = errEv | (errFlag[i] & ~hit[C_CLR_ERR]
                         & ~(strb.wordSel[W_ERR_LO+HALF] & wBit));
    assign doneN[i]  = evDone[i] | (doneFlag[i] & ~hit[C_CLR_DONE]);
    assign startN[i] = hit[C_SET_START];
  end

  assign errLatch = errEvValid && (int'(errEvChan) < NUM_CH) && !errStat[ES_VALID];

  always_comb begin
    errStatNew           = '0;
    errStatNew[ES_VALID] = 1'b1;
    errStatNew[15:14]    = errEvCause[9:8];
    errStatNew[13:8]     = errEvChan;
    errStatNew[7:0]      = errEvCause[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqEn <= '0; eie <= '0; intReq <= '0; errFlag <= '0;
      doneFlag <= '0; startQ <= '0; ctrlReg <= '0; errStat <= '0;
    end else begin
      reqEn    <= reqEnN;
      eie      <= eieN;
      intReq   <= intReqN;
      errFlag  <= errFlagN;
      doneFlag <= doneN;
      startQ   <= startN;
      if (strb.wordSel[W_CTRL]) ctrlReg <= strb.wrData & CTRL_MASK;
      if (errLatch)             errStat <= errStatNew;
      else if (errFlagN == '0)  errStat <= '0;
    end
  end

  function automatic logic [VIEW_W-1:0] widen(input logic [NUM_CH-1:0] v);
    widen = '0;
    widen[NUM_CH-1:0] = v;
  endfunction

  logic [VIEW_W-1:0] vReq, vEie, vInt, vErr, vDone;
  logic [WI_W-1:0]   rdIdx;
  logic [3:0]        unusedSel;

  assign vReq  = widen(reqEn);
  assign vEie  = widen(eie);
  assign vInt  = widen(intReq);
  assign vErr  = widen(errFlag);
  assign vDone = widen(doneFlag);
  assign rdIdx = rdAddr[ADDR_W-1:2];
  assign unusedSel = {strb.wordSel[W_ERRSTAT], strb.wordSel[W_CMDA],
                      strb.wordSel[W_CMDB], ^strb.wordSel[15:12]};

  always_comb begin
    case (int'(rdIdx))
      W_CTRL:         rdData = ctrlReg;
      W_ERRSTAT:      rdData = errStat;
      W_REQEN_LO:     rdData = vReq[31:0];
      W_REQEN_LO + 1: rdData = vReq[63:32];
      W_EIE_LO:       rdData = vEie[31:0];
      W_EIE_LO + 1:   rdData = vEie[63:32];
      W_INT_LO:       rdData = vInt[31:0];
      W_INT_LO + 1:   rdData = vInt[63:32];
      W_ERR_LO:       rdData = vErr[31:0];
      W_ERR_LO + 1:   rdData = vErr[63:32];
      W_DONE_LO:      rdData = vDone[31:0];
      W_DONE_LO + 1:  rdData = vDone[63:32];
      default:        rdData = '0;
    endcase
  end

  assign irq      = (|intReq) | (|(errFlag & eie));
  assign reqEnOut = reqEn;
  assign startOut = startQ;
  assign ctrlOut  = {ctrlReg[31], ctrlReg[3], ctrlReg[2]};

  // R9
  errvalid_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    errStat[ES_VALID] |-> (errFlag != '0));
  // R9
  errstat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errStat[ES_VALID] && $past(errStat[ES_VALID])) |-> $stable(errStat));
  // R10
  pending_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intReq != '0) |-> irq);
  // R11
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(startQ));
  // R12
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evDone != '0) |=> (doneFlag != '0));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmaregs_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWe,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [3:0]            busBe,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  input  logic [NUM_CH-1:0]     evDone,
  input  logic                  errEvValid,
  input  logic [ES_CHAN_W-1:0]  errEvChan,
  input  logic [ES_CAUSE_W-1:0] errEvCause,
  output logic                  irq,
  output logic [NUM_CH-1:0]     chanReqEn,
  output logic [NUM_CH-1:0]     chanStart,
  output logic                  clkGateEn,
  output logic                  rrGroup,
  output logic                  rrChan
);
  strobes_t   strb;
  logic [2:0] ctrlBits;

  dmaregs_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busBe(busBe), .busWdata(busWdata), .strb(strb));

  dmaregs_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(busAddr),
    .evDone(evDone), .errEvValid(errEvValid), .errEvChan(errEvChan),
    .errEvCause(errEvCause), .rdData(busRdata), .irq(irq),
    .reqEnOut(chanReqEn), .startOut(chanStart), .ctrlOut(ctrlBits));

  assign {clkGateEn, rrGroup, rrChan} = ctrlBits;
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        busWe = 0;
  logic [7:0]  busAddr = 0;
  logic [3:0]  busBe = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic [63:0] evDone = 0;
  logic        errEvValid = 0;
  logic [5:0]  errEvChan = 0;
  logic [9:0]  errEvCause = 0;
  logic        irq, clkGateEn, rrGroup, rrChan;
  logic [63:0] chanReqEn, chanStart;
  int nChecks = 0;
  int nErr = 0;

  always #5 clk = ~clk;

  dma_chan_regs u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata), .evDone(evDone),
    .errEvValid(errEvValid), .errEvChan(errEvChan), .errEvCause(errEvCause),
    .irq(irq), .chanReqEn(chanReqEn), .chanStart(chanStart),
    .clkGateEn(clkGateEn), .rrGroup(rrGroup), .rrChan(rrChan));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    busAddr = a; busBe = be; busWdata = d; busWe = 1;
    @(negedge clk);
    busWe = 0; busBe = 0;
  endtask

  task automatic cmd(input int c, input int idx);
    wr((c < 4) ? 8'h08 : 8'h0C, 4'b1 << (c % 4), 32'(idx & 8'hFF) << (8 * (c % 4)));
  endtask

  task automatic rd32(input logic [7:0] a, output logic [31:0] v);
    busAddr = a; #1; v = busRdata;
  endtask

  task automatic rd64(input logic [7:0] a, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd32(a, lo); rd32(a + 8'd4, hi);
    v = {hi, lo};
  endtask

  task automatic pulseDone(input logic [63:0] m);
    evDone = m; @(negedge clk); evDone = 0;
  endtask

  task automatic pulseErr(input int ch, input logic [9:0] cause);
    errEvValid = 1; errEvChan = 6'(ch); errEvCause = cause;
    @(negedge clk); errEvValid = 0;
  endtask

  function automatic logic [31:0] esExp(input int ch, input logic [9:0] cause);
    return 32'h8000_0000 | (32'(cause[9:8]) << 14) | (32'(ch) << 8) | 32'(cause[7:0]);
  endfunction

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] v, model;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    for (int a = 0; a < 14; a++) begin
      rd32(8'(a * 4), w);
      chk("R1 reset word", {32'(a), w}, {32'(a), 32'h0});
    end
    chk("R1 reset outputs", {irq, clkGateEn, rrGroup, rrChan, chanReqEn, chanStart},
        {4'b0, 64'h0, 64'h0});

    // R2 request-enable sweep, R11 start sweep, R3 error-interrupt enable sweep
    for (int ch = 0; ch < 64; ch++) begin
      cmd(0, ch);
      rd64(8'h10, v);
      chk("R2 set req word", v, 64'h1 << ch);
      chk("R2 req output", chanReqEn, 64'h1 << ch);
      cmd(1, ch);
      rd64(8'h10, v);
      chk("R2 clear req", v, 64'h0);
      cmd(2, ch);
      rd64(8'h18, v);
      chk("R3 set eie", v, 64'h1 << ch);
      cmd(3, ch);
      rd64(8'h18, v);
      chk("R3 clear eie", v, 64'h0);
      cmd(6, ch);
      chk("R11 start pulse", chanStart, 64'h1 << ch);
      @(negedge clk);
      chk("R11 start single cycle", chanStart, 64'h0);
    end
    // R2 set and clear in one write: clear wins
    wr(8'h08, 4'b0011, {16'h0, 8'd17, 8'd17});
    rd64(8'h10, v);
    chk("R2 clear wins", v, 64'h0);

    // R5 whole-word writes
    wr(8'h10, 4'hF, 32'hDEAD_BEEF);
    wr(8'h14, 4'hF, 32'h1234_5678);
    model = 64'h1234_5678_DEAD_BEEF;
    rd64(8'h10, v);
    chk("R5 req word write", v, model);
    chk("R5 req output", chanReqEn, model);
    wr(8'h1C, 4'hF, 32'hA5A5_0001);
    rd64(8'h18, v);
    chk("R5 eie word write", v, 64'hA5A5_0001_0000_0000);

    // R4 out-of-range indices ignored on every lane
    for (int k = 0; k < 4; k++) begin
      int bad;
      bad = (k == 0) ? 64 : (k == 1) ? 100 : (k == 2) ? 200 : 255;
      for (int c = 0; c < 8; c++) begin
        cmd(c, bad);
        chk("R4 no start", chanStart, 64'h0);
      end
      rd64(8'h10, v);
      chk("R4 req unchanged", v, model);
      rd64(8'h18, v);
      chk("R4 eie unchanged", v, 64'hA5A5_0001_0000_0000);
    end
    wr(8'h10, 4'hF, 0); wr(8'h14, 4'hF, 0); wr(8'h1C, 4'hF, 0);

    // R6 completion events, single clears, R10 irq from pending
    pulseDone(64'h8000_0001_0000_0009);
    rd64(8'h20, v);
    chk("R6 int set", v, 64'h8000_0001_0000_0009);
    rd64(8'h30, v);
    chk("R6 done set", v, 64'h8000_0001_0000_0009);
    chk("R10 irq pending", irq, 1);
    cmd(4, 63);
    rd64(8'h20, v);
    chk("R6 clear one int", v, 64'h0000_0001_0000_0009);
    cmd(7, 0);
    rd64(8'h30, v);
    chk("R6 clear one done", v, 64'h8000_0001_0000_0008);
    // R7 word clears
    wr(8'h20, 4'hF, 32'h0000_0008);
    rd64(8'h20, v);
    chk("R7 w1c partial", v, 64'h0000_0001_0000_0001);
    wr(8'h24, 4'hF, 32'hFFFF_FFFF);
    wr(8'h20, 4'hF, 32'hFFFF_FFFF);
    rd64(8'h20, v);
    chk("R7 w1c all ones", v, 64'h0);
    chk("R10 irq idle", irq, 0);

    // R12 event and clear in the same cycle
    pulseDone(64'h1 << 9);
    evDone = 64'h1 << 9;
    cmd(4, 9);
    evDone = 0;
    rd64(8'h20, v);
    chk("R12 set wins", v, 64'h1 << 9);
    wr(8'h20, 4'hF, 32'hFFFF_FFFF);

    // R8 first error latched
    pulseErr(40, 10'b10_1010_0101);
    rd32(8'h04, w);
    chk("R8 status latch", w, esExp(40, 10'b10_1010_0101));
    rd64(8'h28, v);
    chk("R8 err flag", v, 64'h1 << 40);
    chk("R10 err masked", irq, 0);
    cmd(2, 40);
    chk("R10 err enabled", irq, 1);
    // R9 later error keeps status
    pulseErr(7, 10'b01_0000_0011);
    rd32(8'h04, w);
    chk("R9 status held", w, esExp(40, 10'b10_1010_0101));
    rd64(8'h28, v);
    chk("R9 second flag", v, (64'h1 << 40) | (64'h1 << 7));
    cmd(5, 40);
    rd32(8'h04, w);
    chk("R9 partial clear keeps", w, esExp(40, 10'b10_1010_0101));
    chk("R10 masked after clear", irq, 0);
    cmd(5, 7);
    rd32(8'h04, w);
    chk("R9 status released", w, 32'h0);
    pulseErr(3, 10'b00_0100_0000);
    rd32(8'h04, w);
    chk("R9 relatch", w, esExp(3, 10'b00_0100_0000));
    // R12 error event against a clear of the same flag
    errEvValid = 1; errEvChan = 6'd3; errEvCause = 10'h001;
    cmd(5, 3);
    errEvValid = 0;
    rd64(8'h28, v);
    chk("R12 err set wins", v, 64'h1 << 3);
    wr(8'h28, 4'hF, 32'hFFFF_FFFF);
    rd32(8'h04, w);
    chk("R9 word clear releases", w, 32'h0);

    // R13 control register
    wr(8'h00, 4'hF, 32'hFFFF_FFFF);
    rd32(8'h00, w);
    chk("R13 ctrl mask", w, 32'h8000_000C);
    chk("R13 mode outputs", {clkGateEn, rrGroup, rrChan}, 3'b111);
    wr(8'h00, 4'hF, 32'h0000_0004);
    chk("R13 round-robin channel only", {clkGateEn, rrGroup, rrChan}, 3'b001);

    summary();
    $finish;
  end
endmodule